// File: doc/BRIEF.md
# Seed-and-cluster hit sparsifier

This block reduces the data coming out of a pixel matrix that is read one row at a time. Every column delivers a 3-bit unsigned sample in parallel with all the others. The block keeps the two previous rows in line buffers. When a new row arrives, it forms a 3x3 window around each interior pixel of the middle row. A window counts as a hit only when two tests both pass. First, its centre sample must be strictly greater than a programmable seed threshold. Second, the sum of its nine samples must be strictly greater than a programmable cluster threshold.

Each hit becomes one record. The record holds the centre row and column address and the nine samples. Records are written into an output FIFO, and the FIFO is read through a valid/ready handshake. Columns are split into groups, and an OR tree over each group's candidate flags lets the scan controller skip empty groups. This way the controller spends exactly one cycle per hit. When the FIFO is full, the scan pauses and the block stops accepting rows, so no record is lost.

Top module: `clus_sparsifier`

## Requirements
- R1: After reset, out_valid is 0 and row_ready is 1.
- R2: A row is taken on a clock edge where row_valid and row_ready are both 1. Column c of the row is row_data[c*3 +: 3]. When row_start is 1, the row taken is row 0 of a new frame, and the rows that follow are numbered 1, 2, 3 and so on.
- R3: The window centred on row r, column c is a hit exactly when two conditions hold: the centre sample is greater than the seed threshold, and the sum of the nine samples is greater than the cluster threshold. Both comparisons are strict, so a value equal to its threshold is rejected.
- R4: On a clock edge where cfg_load is 1, cfg_seed and cfg_clus are stored as the thresholds. Every row taken after that edge is judged against the stored values.
- R5: No window is reported whose centre lies on column 0, on the last column, or on the first or last row of a frame. No window ever mixes rows from two different frames.
- R6: Each record carries out_row = centre row number and out_col = centre column. Tap k = 3*dr + dc sits at out_samples[k*3 +: 3], where dr and dc run from 0 to 2, starting at the top-left pixel of the window (row r-1, column c-1).
- R7: Records for one centre row leave in ascending column order. All records for a row leave before any record of a later row.
- R8: After a row whose windows produce K hits is taken, row_ready stays low for exactly K cycles, provided the FIFO has room. Groups of columns with no hit cost no cycle, and a row with no hit leaves row_ready high.
- R9: While the FIFO is full, the scan pauses and row_ready stays low. No record is lost or repeated under any out_ready pattern.
- R10: While out_valid is 1 and out_ready is 0, the record on the output stays unchanged. out_valid only falls after a handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Store the threshold inputs |
| cfg_seed | input | 3 | Seed threshold for the centre sample |
| cfg_clus | input | 7 | Cluster threshold for the 3x3 sum |
| row_valid | input | 1 | A row is presented |
| row_start | input | 1 | The presented row is row 0 of a new frame |
| row_data | input | 48 | One 3-bit sample per column, column c at bits c*3 +: 3 |
| row_ready | output | 1 | The block can take a row |
| out_valid | output | 1 | A cluster record is available |
| out_ready | input | 1 | The consumer takes the record |
| out_row | output | 7 | Centre row number of the record |
| out_col | output | 4 | Centre column of the record |
| out_samples | output | 27 | Nine window samples, top-left first |

## Verification
The hardest situation to reach from the ports has three parts at once. The FIFO is full, a row with many hits is halfway through its scan, and the consumer is releasing records one at a time. Only then can a stalled scan drop, repeat or reorder a record.

The bench gets there with a dense pseudo-random frame and a low cluster threshold, so most rows produce many hits. It holds out_ready low for the first forty cycles and afterwards raises it only every third cycle. It then compares the whole record stream against a model of the frame. A separate directed row with hits only in the upper column group measures how many cycles row_ready stays low, which shows whether empty groups are skipped.

// File: rtl/clus_pkg.sv
`timescale 1ns/1ps
package clus_pkg;
   localparam int WIN  = 3;
   localparam int TAPS = WIN * WIN;

   typedef enum logic {SCAN_IDLE, SCAN_BUSY} scan_st_t;

   // bits needed for a sum of TAPS samples of sw bits each
   function automatic int sum_width(input int sw);
      return $clog2(TAPS * (2 ** sw));
   endfunction
endpackage

// File: rtl/clus_win_eval.sv
`timescale 1ns/1ps
module clus_win_eval
   import clus_pkg::*;
#(
   parameter int NCOL = 16,
   parameter int SW   = 3,
   parameter int SUMW = 7
) (
   input  logic                 en,
   input  logic [NCOL*SW-1:0]   row_top,
   input  logic [NCOL*SW-1:0]   row_mid,
   input  logic [NCOL*SW-1:0]   row_bot,
   input  logic [SW-1:0]        seed_thr,
   input  logic [SUMW-1:0]      clus_thr,
   output logic [NCOL-1:0]      cand
);
   for (genvar c = 0; c < NCOL; c++) begin : g_col
      if (c == 0 || c == NCOL - 1) begin : g_edge
         assign cand[c] = 1'b0;
      end else begin : g_win
         logic [SUMW-1:0] acc;
         always_comb begin
            acc = '0;
            for (int d = 0; d < WIN; d++) begin
               acc = acc + SUMW'(row_top[(c-1+d)*SW +: SW])
                         + SUMW'(row_mid[(c-1+d)*SW +: SW])
                         + SUMW'(row_bot[(c-1+d)*SW +: SW]);
            end
         end
         assign cand[c] = en && (row_mid[c*SW +: SW] > seed_thr) && (acc > clus_thr);
      end
   end
endmodule

// File: rtl/clus_pick.sv
`timescale 1ns/1ps
module clus_pick #(
   parameter int NCOL  = 16,
   parameter int GROUP = 8,
   parameter int CW    = 4
) (
   input  logic [NCOL-1:0] pend,
   output logic            hit,
   output logic [CW-1:0]   idx
);
   localparam int NGRP = NCOL / GROUP;
   localparam int GW   = (NGRP  > 1) ? $clog2(NGRP)  : 1;
   localparam int GBW  = (GROUP > 1) ? $clog2(GROUP) : 1;

   logic [NGRP-1:0] grp_any;

   for (genvar g = 0; g < NGRP; g++) begin : g_or
      assign grp_any[g] = |pend[g*GROUP +: GROUP];
   end

   if (NGRP == 1) begin : g_flat
      always_comb begin
         idx = '0;
         for (int b = NCOL - 1; b >= 0; b--) begin
            if (pend[b]) idx = CW'(b);
         end
      end
   end else begin : g_grouped
      logic [GW-1:0]    gsel;
      logic [GBW-1:0]   bsel;
      logic [GROUP-1:0] sub;
      always_comb begin
         gsel = '0;
         for (int g = NGRP - 1; g >= 0; g--) begin
            if (grp_any[g]) gsel = GW'(g);
         end
         sub  = pend[int'(gsel)*GROUP +: GROUP];
         bsel = '0;
         for (int b = GROUP - 1; b >= 0; b--) begin
            if (sub[b]) bsel = GBW'(b);
         end
         idx = CW'(int'(gsel) * GROUP + int'(bsel));
      end
   end

   assign hit = |grp_any;
endmodule

// File: rtl/clus_fifo.sv
`timescale 1ns/1ps
module clus_fifo #(
   parameter int W     = 38,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (2 ** AW) != DEPTH) begin : g_bad_depth
      $error("clus_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   cnt;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = mem[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push && !full) begin
            mem[wptr] <= din;
            wptr      <= wptr + AW'(1);
         end
         if (pop && !empty) rptr <= rptr + AW'(1);
         case ({push && !full, pop && !empty})
            2'b10:   cnt <= cnt + (AW+1)'(1);
            2'b01:   cnt <= cnt - (AW+1)'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/clus_sparsifier.sv
`timescale 1ns/1ps
module clus_sparsifier
   import clus_pkg::*;
#(
   parameter int NCOL   = 16,
   parameter int GROUP  = 8,
   parameter int SW     = 3,
   parameter int NROW   = 100,
   parameter int FDEPTH = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_load,
   input  logic [SW-1:0]                      cfg_seed,
   input  logic [clus_pkg::sum_width(SW)-1:0] cfg_clus,
   input  logic                               row_valid,
   input  logic                               row_start,
   input  logic [NCOL*SW-1:0]                 row_data,
   output logic                               row_ready,
   output logic                               out_valid,
   input  logic                               out_ready,
   output logic [$clog2(NROW)-1:0]            out_row,
   output logic [$clog2(NCOL)-1:0]            out_col,
   output logic [clus_pkg::TAPS*SW-1:0]       out_samples
);
   localparam int CW   = $clog2(NCOL);
   localparam int RW   = $clog2(NROW);
   localparam int SUMW = sum_width(SW);
   localparam int LW   = NCOL * SW;
   localparam int SMPW = TAPS * SW;
   localparam int RECW = RW + CW + SMPW;

   if (NCOL < WIN) begin : g_bad_ncol
      $error("clus_sparsifier: NCOL must be at least the window width");
   end
   if (GROUP < 1 || (NCOL % GROUP) != 0) begin : g_bad_group
      $error("clus_sparsifier: GROUP must divide NCOL");
   end
   if (SW < 1 || NROW < 3) begin : g_bad_misc
      $error("clus_sparsifier: SW and NROW out of range");
   end

   // threshold registers
   logic [SW-1:0]   seed_q;
   logic [SUMW-1:0] clus_q;

   // line buffers and frame position
   logic [LW-1:0] lb_old, lb_new;
   logic [1:0]    fill;
   logic [RW-1:0] row_cnt, cur_row;
   logic          win_en, accept;

   // row under scan
   logic [LW-1:0]   ev_rows [WIN];
   logic [RW-1:0]   ev_row;
   logic [NCOL-1:0] pending, cand, clr, pend_nx;
   scan_st_t        st;

   logic            sel_hit;
   logic [CW-1:0]   sel_idx;
   logic            push, fifo_full, fifo_empty;
   logic [SMPW-1:0] rec_smp;
   logic [RECW-1:0] fifo_dout;

   assign row_ready = (st == SCAN_IDLE);
   assign accept    = row_valid && row_ready;
   assign cur_row   = row_start ? '0 : row_cnt;
   assign win_en    = !row_start && (fill == 2'd2);

   clus_win_eval #(.NCOL(NCOL), .SW(SW), .SUMW(SUMW)) u_eval (
      .en       (win_en),
      .row_top  (lb_old),
      .row_mid  (lb_new),
      .row_bot  (row_data),
      .seed_thr (seed_q),
      .clus_thr (clus_q),
      .cand     (cand)
   );

   clus_pick #(.NCOL(NCOL), .GROUP(GROUP), .CW(CW)) u_pick (
      .pend (pending),
      .hit  (sel_hit),
      .idx  (sel_idx)
   );

   assign push    = (st == SCAN_BUSY) && sel_hit && !fifo_full;
   assign clr     = push ? (NCOL'(1) << sel_idx) : '0;
   assign pend_nx = pending & ~clr;

   // gather the nine taps around the selected centre, top-left first
   always_comb begin
      rec_smp = '0;
      for (int dr = 0; dr < WIN; dr++) begin
         for (int dc = 0; dc < WIN; dc++) begin
            int col;
            col = int'(sel_idx) + dc - 1;
            if (col < 0)        col = 0;
            if (col > NCOL - 1) col = NCOL - 1;
            rec_smp[(dr*WIN+dc)*SW +: SW] = ev_rows[dr][col*SW +: SW];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seed_q  <= '0;
         clus_q  <= '0;
         lb_old  <= '0;
         lb_new  <= '0;
         fill    <= '0;
         row_cnt <= '0;
         ev_row  <= '0;
         pending <= '0;
         st      <= SCAN_IDLE;
         for (int i = 0; i < WIN; i++) ev_rows[i] <= '0;
      end else begin
         if (cfg_load) begin
            seed_q <= cfg_seed;
            clus_q <= cfg_clus;
         end
         if (accept) begin
            lb_old     <= lb_new;
            lb_new     <= row_data;
            fill       <= row_start ? 2'd1 : ((fill == 2'd2) ? 2'd2 : fill + 2'd1);
            row_cnt    <= cur_row + RW'(1);
            ev_rows[0] <= lb_old;
            ev_rows[1] <= lb_new;
            ev_rows[2] <= row_data;
            ev_row     <= cur_row - RW'(1);
            pending    <= cand;
            st         <= (|cand) ? SCAN_BUSY : SCAN_IDLE;
         end else if (st == SCAN_BUSY) begin
            pending <= pend_nx;
            if (pend_nx == '0) st <= SCAN_IDLE;
         end
      end
   end

   clus_fifo #(.W(RECW), .DEPTH(FDEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   ({ev_row, sel_idx, rec_smp}),
      .full  (fifo_full),
      .pop   (out_valid && out_ready),
      .dout  (fifo_dout),
      .empty (fifo_empty)
   );

   assign out_valid = !fifo_empty;
   assign {out_row, out_col, out_samples} = fifo_dout;
endmodule

// File: rtl/clus_sparsifier_chk.sv
`timescale 1ns/1ps
module clus_sparsifier_chk #(
   parameter int NCOL = 16,
   parameter int CW   = 4,
   parameter int RW   = 7,
   parameter int SMPW = 27
) (
   input logic            clk,
   input logic            rst_n,
   input logic            push,
   input logic [CW-1:0]   push_col,
   input logic            fifo_full,
   input logic            row_ready,
   input logic            out_valid,
   input logic            out_ready,
   input logic [RW-1:0]   out_row,
   input logic [CW-1:0]   out_col,
   input logic [SMPW-1:0] out_samples
);
   // R7
   col_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && $past(push) |-> push_col > $past(push_col));

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_row) && $stable(out_col) && $stable(out_samples));

   // R10
   out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ready));

   // R5
   edge_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_col != '0) && (int'(out_col) <= NCOL - 2));

   // R8
   busy_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !row_ready && !fifo_full |-> push);
endmodule

bind clus_sparsifier clus_sparsifier_chk #(.NCOL(NCOL), .CW(CW), .RW(RW), .SMPW(SMPW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push        (push),
   .push_col    (sel_idx),
   .fifo_full   (fifo_full),
   .row_ready   (row_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_row     (out_row),
   .out_col     (out_col),
   .out_samples (out_samples)
);

// File: tb/clus_sparsifier_test.sv
`timescale 1ns/1ps
module clus_sparsifier_test;
   localparam int NCOL = 16, GROUP = 8, SW = 3, NROW = 100, FDEPTH = 4;
   localparam int CW = 4, RW = 7, SUMW = 7, SMPW = 27;

   logic            clk = 0, rst_n = 0;
   logic            cfg_load = 0;
   logic [SW-1:0]   cfg_seed = '0;
   logic [SUMW-1:0] cfg_clus = '0;
   logic            row_valid = 0, row_start = 0;
   logic [NCOL*SW-1:0] row_data = '0;
   logic            row_ready, out_valid;
   logic            out_ready = 0;
   logic [RW-1:0]   out_row;
   logic [CW-1:0]   out_col;
   logic [SMPW-1:0] out_samples;

   clus_sparsifier #(.NCOL(NCOL), .GROUP(GROUP), .SW(SW), .NROW(NROW), .FDEPTH(FDEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_seed(cfg_seed), .cfg_clus(cfg_clus),
      .row_valid(row_valid), .row_start(row_start), .row_data(row_data), .row_ready(row_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row), .out_col(out_col),
      .out_samples(out_samples)
   );

   always #4 clk = ~clk;

   int n_run = 0, n_fail = 0;
   int frm [16][16];
   int seed_v, clus_v;
   int e_row [512], e_col [512];
   logic [SMPW-1:0] e_smp [512];
   int n_exp;
   int l_row [512], l_col [512];
   logic [SMPW-1:0] l_smp [512];
   int n_log = 0;
   int rdy_mode = 0, rdy_cnt = 0;
   logic hold_v = 0;
   logic [RW+CW+SMPW-1:0] hold_rec;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // output side: drive ready, log records, check hold
   always @(negedge clk) begin
      if (rst_n) begin
         bit rdy;
         if (hold_v)
            chk(out_valid && ({out_row, out_col, out_samples} == hold_rec),
                "R10 record held while out_ready low", {out_row, out_col, out_samples}, hold_rec);
         rdy_cnt++;
         rdy = (rdy_mode == 0) ? 1'b1 : ((rdy_cnt > 40) && (rdy_cnt % 3 == 0));
         out_ready = rdy;
         if (out_valid && rdy && n_log < 512) begin
            l_row[n_log] = int'(out_row);
            l_col[n_log] = int'(out_col);
            l_smp[n_log] = out_samples;
            n_log++;
         end
         hold_v   = out_valid && !rdy;
         hold_rec = {out_row, out_col, out_samples};
      end
   end

   task automatic clear_frame();
      for (int r = 0; r < 16; r++) for (int c = 0; c < 16; c++) frm[r][c] = 0;
   endtask

   task automatic load_thr(input int s, input int cth);
      @(negedge clk);
      cfg_load = 1; cfg_seed = SW'(s); cfg_clus = SUMW'(cth);
      @(negedge clk);
      cfg_load = 0;
      seed_v = s; clus_v = cth;
   endtask

   task automatic model(input int nr);
      n_exp = 0;
      for (int r = 1; r < nr - 1; r++) begin
         for (int c = 1; c < NCOL - 1; c++) begin
            int sum;
            logic [SMPW-1:0] s;
            sum = 0; s = '0;
            for (int dr = 0; dr < 3; dr++) begin
               for (int dc = 0; dc < 3; dc++) begin
                  sum += frm[r-1+dr][c-1+dc];
                  s[(dr*3+dc)*3 +: 3] = 3'(frm[r-1+dr][c-1+dc]);
               end
            end
            if (frm[r][c] > seed_v && sum > clus_v) begin
               e_row[n_exp] = r; e_col[n_exp] = c; e_smp[n_exp] = s;
               n_exp++;
            end
         end
      end
   endtask

   task automatic send_row(input int r, input bit start, output int busy);
      @(negedge clk);
      while (!row_ready) @(negedge clk);
      row_valid = 1; row_start = start;
      for (int c = 0; c < NCOL; c++) row_data[c*SW +: SW] = SW'(frm[r][c]);
      @(negedge clk);
      row_valid = 0; row_start = 0;
      busy = 0;
      while (!row_ready) begin
         busy++;
         @(negedge clk);
      end
   endtask

   task automatic drain(input int want);
      int w;
      w = 0;
      while (n_log < want && w < 3000) begin
         @(negedge clk);
         w++;
      end
      repeat (20) @(negedge clk);
   endtask

   task automatic run_frame(input int nr, input string tag);
      int b;
      n_log = 0;
      model(nr);
      for (int r = 0; r < nr; r++) send_row(r, r == 0, b);
      drain(n_exp);
      chk(n_log == n_exp, {tag, " R7 record count"}, n_log, n_exp);
      for (int i = 0; i < n_exp && i < n_log; i++) begin
         chk(l_row[i] == e_row[i], {tag, " R2 centre row"}, l_row[i], e_row[i]);
         chk(l_col[i] == e_col[i], {tag, " R7 column order"}, l_col[i], e_col[i]);
         chk(l_smp[i] == e_smp[i], {tag, " R6 samples"}, l_smp[i], e_smp[i]);
      end
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      chk(row_ready == 1'b1, "R1 row_ready after reset", row_ready, 1);
   endtask

   task automatic t_single();
      clear_frame();
      for (int dr = -1; dr <= 1; dr++) for (int dc = -1; dc <= 1; dc++) frm[3+dr][5+dc] = 1;
      frm[3][5] = 6;
      frm[2][4] = 2;
      load_thr(4, 10);
      run_frame(6, "R3 R6 single cluster");
      chk(n_log == 1, "R3 single cluster found", n_log, 1);
   endtask

   task automatic t_strict();
      clear_frame();
      // A: centre equals seed; B: sum equals cluster threshold; C: passes
      for (int dr = 1; dr <= 3; dr++) for (int dc = 2; dc <= 4; dc++) frm[dr][dc] = 2;
      frm[2][3] = 5;
      for (int dr = 1; dr <= 3; dr++) for (int dc = 7; dc <= 9; dc++) frm[dr][dc] = 2;
      frm[3][9] = 0;
      frm[2][8] = 6;
      for (int dr = 1; dr <= 3; dr++) for (int dc = 11; dc <= 13; dc++) frm[dr][dc] = 2;
      frm[2][12] = 6;
      load_thr(5, 20);
      run_frame(5, "R3 strict compare");
      chk(n_log == 1 && l_col[0] == 12, "R3 only strictly greater accepted", l_col[0], 12);
   endtask

   task automatic t_edges();
      clear_frame();
      for (int i = 0; i < 16; i++) begin
         frm[0][i] = 7; frm[5][i] = 7; frm[i % 6][0] = 7; frm[i % 6][15] = 7;
      end
      load_thr(0, 0);
      run_frame(6, "R5 border");
      chk(n_log == 0, "R5 no window centred on border", n_log, 0);
      frm[1][1] = 1;
      frm[4][14] = 1;
      run_frame(6, "R5 corner windows");
      chk(n_log == 2, "R5 interior corners only", n_log, 2);
   endtask

   task automatic t_busy();
      int b;
      clear_frame();
      frm[1][9] = 7; frm[1][11] = 7; frm[1][13] = 7;
      load_thr(3, 6);
      n_log = 0;
      send_row(0, 1, b);
      chk(b == 0, "R8 first row no scan", b, 0);
      send_row(1, 0, b);
      chk(b == 0, "R8 second row no scan", b, 0);
      send_row(2, 0, b);
      chk(b == 3, "R8 one cycle per hit, empty group skipped", b, 3);
      send_row(3, 0, b);
      chk(b == 0, "R8 row without hits", b, 0);
      drain(3);
      chk(n_log == 3, "R8 record count", n_log, 3);
      chk(l_col[0] == 9 && l_col[1] == 11 && l_col[2] == 13, "R7 ascending columns",
          {l_col[0][7:0], l_col[1][7:0], l_col[2][7:0]}, 24'h090b0d);
   endtask

   task automatic t_dense();
      int unsigned x;
      x = 32'h1234_5678;
      clear_frame();
      for (int r = 0; r < 10; r++) begin
         for (int c = 0; c < 16; c++) begin
            x = x * 1103515245 + 12345;
            frm[r][c] = int'((x >> 16) & 7);
         end
      end
      load_thr(3, 25);
      rdy_cnt = 0;
      rdy_mode = 1;
      run_frame(10, "R9 dense frame with output stall");
      rdy_mode = 0;
      load_thr(5, 35);
      run_frame(10, "R4 reloaded thresholds");
   endtask

   task automatic t_restart();
      for (int r = 0; r < 4; r++) for (int c = 0; c < 16; c++) frm[r][c] = 7;
      load_thr(2, 10);
      run_frame(4, "R2 R5 frame restart");
      chk(n_log == 28, "R5 new frame does not reuse old rows", n_log, 28);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_single();
      t_strict();
      t_edges();
      t_busy();
      t_dense();
      t_restart();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule